// File: doc/BRIEF.md
# SPI Master with Queue-Framed Slave Select

The block is a four-wire SPI master. Software-side logic pushes words into a transmit queue and pops captured words from a receive queue. The active-low slave select is not strobed separately. It falls when the transmit queue holds a word, and it rises again according to the framing mode.

In separated framing, select is released after every word. In continuous framing, select stays low while words remain queued. This lets a command byte followed by dummy bytes form one frame, with the read data landing in the receive queue.

Words are 8 or 16 bits. One storage array of 16 x 16 bits per direction holds 16 wide words or 32 narrow ones. The serial clock runs at the system clock divided by twice a programmable half-period count.

Top module: `spi_qframe_master`

## Requirements
- R1: After reset, ss_no is 1, sclk_o is 0, tx_full_o, rx_valid_o, tx_ovf_o and rx_ovr_o are 0, and the active configuration is narrow (cfg_wide_o=0) and separated (cfg_cont_o=0).
- R2: Bus timing is SPI mode 0. sclk_o is low whenever ss_no is high. mosi_o carries the most significant bit first and is stable while sclk_o is high. miso_i is captured on each rising sclk_o edge.
- R3: The first rising sclk_o edge of a frame comes exactly clk_div_i system cycles after ss_no falls.
- R4: Each sclk_o phase lasts clk_div_i system cycles (a value of 0 acts as 1), so consecutive rising edges inside a frame are 2*clk_div_i cycles apart.
- R5: In continuous mode (cfg_cont_o=1), if the next word is queued by the time the current word's last bit ends, ss_no stays low and the next rising edge keeps the 2*clk_div_i spacing.
- R6: In both modes, ss_no returns high after the last queued word's final falling edge, once the transmit queue is empty.
- R7: In separated mode (cfg_cont_o=0), ss_no goes high after every word and stays high for at least 2*clk_div_i cycles before the next word starts.
- R8: Received words enter the receive queue in bit order, and rx_data_o shows the oldest one. A narrow word sends tx_data_i[7:0] and returns its byte in rx_data_o[7:0] with bits 15:8 zero. In continuous mode, word k of a frame holds frame bits k*W to k*W+W-1, where W is the word width.
- R9: Each queue holds 16 entries in wide mode (cfg_wide_o=1) and 32 entries in narrow mode. tx_full_o is 1 when the transmit queue holds that many entries.
- R10: A tx_wr_i pulse while tx_full_o is 1 is discarded and sets tx_ovf_o. tx_ovf_o stays 1 until reset.
- R11: A word received while the receive queue is full is discarded and sets rx_ovr_o. rx_ovr_o stays 1 until reset, and the stored entries are kept.
- R12: A cfg_we_i pulse loads cfg_wide_i and cfg_cont_i only when no word is shifting, ss_no is high and both queues are empty. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | SCLK half-period in system cycles |
| cfg_we_i | input | 1 | Configuration load request |
| cfg_wide_i | input | 1 | Requested width: 1 = 16-bit, 0 = 8-bit |
| cfg_cont_i | input | 1 | Requested framing: 1 = continuous, 0 = separated |
| cfg_wide_o | output | 1 | Active width |
| cfg_cont_o | output | 1 | Active framing |
| tx_wr_i | input | 1 | Push tx_data_i into the transmit queue |
| tx_data_i | input | WORD_W | Transmit word |
| tx_full_o | output | 1 | Transmit queue full |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_pop_i | input | 1 | Remove the oldest received word |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_data_o | output | WORD_W | Oldest received word |
| rx_ovr_o | output | 1 | Sticky receive overrun |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Slave select, active low |

## Verification
A write to tx_wr_i lands in the queue at the next edge. Slave select falls one edge later, and the first rising sclk_o edge follows clk_div_i cycles after that. A received word is visible on rx_valid_o right after the edge of its last falling sclk_o. Configuration and the sticky flags change at the edge after their cause.

The bench drives inputs and samples outputs on the falling system clock. A cycle-counting monitor measures setup, SCLK spacing and select-high gaps against clk_div_i. Queue, flag and configuration results are read only after waits longer than every latency listed above.

// File: rtl/spi_qframe_pkg.sv
package spi_qframe_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_XFER = 2'd1,
    ENG_GAP  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_qframe_fifo.sv
module spi_qframe_fifo #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int HALF  = WORD_W / 2;
  localparam int SLOTS = 2 * WORDS;
  localparam int AW    = $clog2(SLOTS);
  localparam int CW    = AW + 1;

  logic [WORD_W-1:0] mem [WORDS];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q, depth;
  logic              do_wr, do_rd;
  logic [WORD_W-1:0] rword;
  logic [HALF-1:0]   rlane;

  assign depth   = wide_i ? CW'(WORDS) : CW'(SLOTS);
  assign full_o  = (cnt_q == depth);
  assign empty_o = (cnt_q == '0);
  assign do_wr   = wr_i && !full_o && !clr_i;
  assign do_rd   = rd_i && !empty_o && !clr_i;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] d);
    return ((CW'(p) + 1'b1) == d) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= bump(wp_q, depth);
      if (do_rd) rp_q <= bump(rp_q, depth);
      if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
    end
  end

  // narrow words share one storage row, two lanes per row
  always_ff @(posedge clk_i) begin
    if (do_wr) begin
      if (wide_i)     mem[wp_q[AW-2:0]] <= wdata_i;
      else if (wp_q[0]) mem[wp_q[AW-1:1]][WORD_W-1:HALF] <= wdata_i[HALF-1:0];
      else              mem[wp_q[AW-1:1]][HALF-1:0]      <= wdata_i[HALF-1:0];
    end
  end

  assign rword   = wide_i ? mem[rp_q[AW-2:0]] : mem[rp_q[AW-1:1]];
  assign rlane   = rp_q[0] ? rword[WORD_W-1:HALF] : rword[HALF-1:0];
  assign rdata_o = wide_i ? rword : {{(WORD_W-HALF){1'b0}}, rlane};

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= depth);
  assert_full_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i && !clr_i) |=> full_o);
endmodule

// File: rtl/spi_qframe_engine.sv
module spi_qframe_engine
  import spi_qframe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wide_i,
  input  logic              cont_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              idle_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_no
);
  localparam int HALF = WORD_W / 2;
  localparam int BW   = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_WIDE   = BW'(WORD_W - 1);
  localparam logic [BW-1:0] LAST_NARROW = BW'(HALF - 1);

  eng_state_e        state_q;
  logic [DIV_W-1:0]  div_cnt_q, half_c;
  logic [DIV_W:0]    gap_cnt_q;
  logic [BW-1:0]     bit_cnt_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, load_word;
  logic              sclk_q, ss_n_q, tick, last_bit, word_end, chain;

  assign half_c    = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick      = (div_cnt_q == half_c - 1'b1);
  assign last_bit  = (bit_cnt_q == (wide_i ? LAST_WIDE : LAST_NARROW));
  assign word_end  = (state_q == ENG_XFER) && tick && sclk_q && last_bit;
  assign chain     = cont_i && !tx_empty_i;
  assign load_word = wide_i ? tx_data_i : {tx_data_i[HALF-1:0], {(WORD_W-HALF){1'b0}}};

  assign tx_pop_o  = ((state_q == ENG_IDLE) && !tx_empty_i) || (word_end && chain);
  assign rx_push_o = word_end;
  assign rx_data_o = wide_i ? rx_sh_q : {{(WORD_W-HALF){1'b0}}, rx_sh_q[HALF-1:0]};
  assign idle_o    = (state_q == ENG_IDLE);
  assign sclk_o    = sclk_q;
  assign ss_no     = ss_n_q;
  assign mosi_o    = tx_sh_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ENG_IDLE;
      div_cnt_q <= '0;
      gap_cnt_q <= '0;
      bit_cnt_q <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      sclk_q    <= 1'b0;
      ss_n_q    <= 1'b1;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (!tx_empty_i) begin
            state_q   <= ENG_XFER;
            ss_n_q    <= 1'b0;
            sclk_q    <= 1'b0;
            div_cnt_q <= '0;
            bit_cnt_q <= '0;
            tx_sh_q   <= load_word;
          end
        end
        ENG_XFER: begin
          if (!tick) begin
            div_cnt_q <= div_cnt_q + 1'b1;
          end else begin
            div_cnt_q <= '0;
            if (!sclk_q) begin
              sclk_q  <= 1'b1;
              rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
            end else begin
              sclk_q <= 1'b0;
              if (!last_bit) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                tx_sh_q   <= {tx_sh_q[WORD_W-2:0], 1'b0};
              end else if (chain) begin
                // back-to-back word, select held, no idle phase
                bit_cnt_q <= '0;
                tx_sh_q   <= load_word;
              end else begin
                ss_n_q    <= 1'b1;
                state_q   <= ENG_GAP;
                gap_cnt_q <= '0;
              end
            end
          end
        end
        ENG_GAP: begin
          gap_cnt_q <= gap_cnt_q + 1'b1;
          if (gap_cnt_q == {half_c, 1'b0} - 1'b1) state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assert_sclk_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o);
  assert_mosi_stable_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  assert_select_before_clock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(!ss_no));
  assert_select_rise_on_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_no) |-> $past(rx_push_o));
endmodule

// File: rtl/spi_qframe_master.sv
module spi_qframe_master #(
  parameter int WORD_W     = 16,
  parameter int FIFO_WORDS = 16,
  parameter int DIV_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              cfg_we_i,
  input  logic              cfg_wide_i,
  input  logic              cfg_cont_i,
  output logic              cfg_wide_o,
  output logic              cfg_cont_o,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_full_o,
  output logic              tx_ovf_o,
  input  logic              rx_pop_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_ovr_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_no
);
  logic              wide_q, cont_q, tx_ovf_q, rx_ovr_q;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push, eng_idle, cfg_take;
  logic [WORD_W-1:0] tx_head, rx_word;

  assign cfg_take = cfg_we_i && eng_idle && ss_no && tx_empty && rx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q   <= 1'b0;
      cont_q   <= 1'b0;
      tx_ovf_q <= 1'b0;
      rx_ovr_q <= 1'b0;
    end else begin
      if (cfg_take) begin
        wide_q <= cfg_wide_i;
        cont_q <= cfg_cont_i;
      end
      if (tx_wr_i && tx_full)  tx_ovf_q <= 1'b1;
      if (rx_push && rx_full)  rx_ovr_q <= 1'b1;
    end
  end

  spi_qframe_fifo #(.WORD_W(WORD_W), .WORDS(FIFO_WORDS)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (wide_q),
    .clr_i   (cfg_take),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_data_i),
    .rd_i    (tx_pop),
    .rdata_o (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  spi_qframe_fifo #(.WORD_W(WORD_W), .WORDS(FIFO_WORDS)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wide_i  (wide_q),
    .clr_i   (cfg_take),
    .wr_i    (rx_push),
    .wdata_i (rx_word),
    .rd_i    (rx_pop_i),
    .rdata_o (rx_data_o),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  spi_qframe_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (clk_div_i),
    .wide_i     (wide_q),
    .cont_i     (cont_q),
    .tx_empty_i (tx_empty),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_word),
    .idle_o     (eng_idle),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .miso_i     (miso_i),
    .ss_no      (ss_no)
  );

  assign cfg_wide_o = wide_q;
  assign cfg_cont_o = cont_q;
  assign tx_full_o  = tx_full;
  assign tx_ovf_o   = tx_ovf_q;
  assign rx_valid_o = !rx_empty;
  assign rx_ovr_o   = rx_ovr_q;

  assert_tx_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o);
  assert_rx_ovr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_o |=> rx_ovr_o);
  assert_cfg_frozen_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_no || rx_valid_o) |=> ($stable(cfg_wide_o) && $stable(cfg_cont_o)));
endmodule

// File: tb/tb_spi_qframe_master.sv
module tb_spi_qframe_master;
  localparam logic [63:0] SLV = 64'hC3A5_5A3C_F00F_1248;

  typedef struct packed {
    logic       wide;
    logic       cont;
    logic [2:0] nwords;
    logic [7:0] half;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{wide: 1'b0, cont: 1'b0, nwords: 3'd2, half: 8'd1},
    '{wide: 1'b0, cont: 1'b1, nwords: 3'd3, half: 8'd2},
    '{wide: 1'b1, cont: 1'b0, nwords: 3'd2, half: 8'd3},
    '{wide: 1'b1, cont: 1'b1, nwords: 3'd2, half: 8'd1},
    '{wide: 1'b0, cont: 1'b1, nwords: 3'd4, half: 8'd3},
    '{wide: 1'b1, cont: 1'b0, nwords: 3'd1, half: 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  clk_div_i = 8'd1;
  logic        cfg_we_i = 1'b0, cfg_wide_i = 1'b0, cfg_cont_i = 1'b0;
  logic        cfg_wide_o, cfg_cont_o;
  logic        tx_wr_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        tx_full_o, tx_ovf_o, rx_pop_i = 1'b0, rx_valid_o, rx_ovr_o;
  logic [15:0] rx_data_o;
  logic        sclk_o, mosi_o, ss_no;
  logic        miso_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_qframe_master dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_div_i(clk_div_i),
    .cfg_we_i(cfg_we_i), .cfg_wide_i(cfg_wide_i), .cfg_cont_i(cfg_cont_i),
    .cfg_wide_o(cfg_wide_o), .cfg_cont_o(cfg_cont_o),
    .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .tx_full_o(tx_full_o), .tx_ovf_o(tx_ovf_o),
    .rx_pop_i(rx_pop_i), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_ovr_o(rx_ovr_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_no(ss_no)
  );

  // bus monitor and slave model, all on the falling system clock
  logic        mon_clr = 1'b0;
  int          cyc = 0, frames, bits, slv_idx, hi_run, fall_cyc, last_rise, viol;
  int          min_hi, min_rise, max_rise, min_setup, max_setup;
  logic        prev_ss = 1'b1, prev_sclk = 1'b0, have_rise, pend_setup;
  logic [63:0] mosi_log;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      frames = 0; bits = 0; slv_idx = 0; hi_run = 0; fall_cyc = 0; last_rise = 0; viol = 0;
      min_hi = 1 << 30; min_rise = 1 << 30; max_rise = 0;
      min_setup = 1 << 30; max_setup = 0;
      have_rise = 1'b0; pend_setup = 1'b0; mosi_log = '0;
    end else begin
      if (ss_no && sclk_o) viol++;
      if (prev_ss && !ss_no) begin
        if (frames > 0 && hi_run < min_hi) min_hi = hi_run;
        frames++;
        fall_cyc = cyc; pend_setup = 1'b1; have_rise = 1'b0;
        slv_idx = 0;
        miso_i = SLV[63];
      end
      if (ss_no) hi_run++; else hi_run = 0;
      if (prev_sclk && !sclk_o) begin
        slv_idx++;
        miso_i = (slv_idx < 64) ? SLV[63 - slv_idx] : 1'b0;
      end
      if (sclk_o && !prev_sclk) begin
        bits++;
        mosi_log = {mosi_log[62:0], mosi_o};
        if (pend_setup) begin
          if (cyc - fall_cyc < min_setup) min_setup = cyc - fall_cyc;
          if (cyc - fall_cyc > max_setup) max_setup = cyc - fall_cyc;
          pend_setup = 1'b0;
        end
        if (have_rise) begin
          if (cyc - last_rise < min_rise) min_rise = cyc - last_rise;
          if (cyc - last_rise > max_rise) max_rise = cyc - last_rise;
        end
        last_rise = cyc; have_rise = 1'b1;
      end
    end
    prev_ss = ss_no;
    prev_sclk = sclk_o;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic mon_reset();
    mon_clr = 1'b1;
    repeat (2) @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic set_cfg(input logic w, input logic c);
    cfg_wide_i = w; cfg_cont_i = c; cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    tx_wr_i = 1'b1; tx_data_i = w;
    @(negedge clk);
    tx_wr_i = 1'b0;
  endtask

  task automatic pop();
    rx_pop_i = 1'b1;
    @(negedge clk);
    rx_pop_i = 1'b0;
  endtask

  function automatic logic [15:0] tx_word(input int v, input int k);
    return 16'h9A5C ^ 16'(k * 16'h1357) ^ 16'(v * 16'h0F0F);
  endfunction

  function automatic logic [15:0] slv_word(input int start, input int w);
    logic [15:0] r = '0;
    for (int j = 0; j < w; j++) r = {r[14:0], SLV[63 - (start + j)]};
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(ss_no == 1'b1 && sclk_o == 1'b0, "R1", "ss/sclk", {ss_no, sclk_o}, 2'b10);
    chk({tx_full_o, rx_valid_o, tx_ovf_o, rx_ovr_o} == 4'b0, "R1", "flags",
        {tx_full_o, rx_valid_o, tx_ovf_o, rx_ovr_o}, 0);
    chk({cfg_wide_o, cfg_cont_o} == 2'b00, "R1", "cfg", {cfg_wide_o, cfg_cont_o}, 0);

    for (int v = 0; v < 6; v++) begin
      int n, w, h;
      logic [63:0] exp_log;
      n = int'(VECS[v].nwords); w = VECS[v].wide ? 16 : 8; h = int'(VECS[v].half);
      clk_div_i = VECS[v].half;
      set_cfg(VECS[v].wide, VECS[v].cont);
      chk(cfg_wide_o == VECS[v].wide && cfg_cont_o == VECS[v].cont, "R12", "cfg accepted idle",
          {cfg_wide_o, cfg_cont_o}, {VECS[v].wide, VECS[v].cont});
      mon_reset();
      exp_log = '0;
      for (int k = 0; k < n; k++) begin
        for (int j = w - 1; j >= 0; j--) exp_log = {exp_log[62:0], tx_word(v, k)[j]};
        push(tx_word(v, k));
      end
      repeat (n * (w * 2 * h + 2 * h + 4) + 30) @(negedge clk);
      chk(frames == (VECS[v].cont ? 1 : n), VECS[v].cont ? "R5" : "R7", "frame count",
          frames, VECS[v].cont ? 1 : n);
      chk(bits == n * w, "R2", "sclk rises", bits, n * w);
      chk(mosi_log == exp_log, "R2", "mosi bits msb first", mosi_log, exp_log);
      chk(viol == 0, "R2", "sclk high with ss high", viol, 0);
      chk(min_setup == h && max_setup == h, "R3", "ss to first rise", min_setup, h);
      chk(min_rise == 2 * h, "R4", "rise spacing", min_rise, 2 * h);
      if (VECS[v].cont)
        chk(max_rise == 2 * h, "R5", "no gap between words", max_rise, 2 * h);
      if (!VECS[v].cont && n > 1)
        chk(min_hi >= 2 * h, "R7", "ss high gap", min_hi, 2 * h);
      chk(ss_no == 1'b1, "R6", "ss released at end", ss_no, 1);
      for (int k = 0; k < n; k++) begin
        logic [15:0] e;
        e = slv_word(VECS[v].cont ? k * w : 0, w);
        chk(rx_valid_o && rx_data_o == e, "R8", "rx word", rx_data_o, e);
        pop();
      end
      chk(rx_valid_o == 1'b0, "R8", "rx drained", rx_valid_o, 0);
    end

    // R12: rejected while busy and while rx holds data
    do_reset();
    clk_div_i = 8'd20;
    push(16'h0011); push(16'h0022);
    repeat (5) @(negedge clk);
    set_cfg(1'b1, 1'b1);
    chk({cfg_wide_o, cfg_cont_o} == 2'b00, "R12", "cfg ignored while shifting",
        {cfg_wide_o, cfg_cont_o}, 0);
    repeat (2 * (8 * 40 + 60)) @(negedge clk);
    set_cfg(1'b1, 1'b1);
    chk({cfg_wide_o, cfg_cont_o} == 2'b00, "R12", "cfg ignored rx nonempty",
        {cfg_wide_o, cfg_cont_o}, 0);
    pop(); pop();
    set_cfg(1'b1, 1'b1);
    chk({cfg_wide_o, cfg_cont_o} == 2'b11, "R12", "cfg taken when idle",
        {cfg_wide_o, cfg_cont_o}, 2'b11);

    // R9/R10: wide depth 16
    do_reset();
    clk_div_i = 8'd50;
    set_cfg(1'b1, 1'b0);
    for (int k = 0; k < 17; k++) push(16'(k));
    chk(tx_full_o == 1'b1 && tx_ovf_o == 1'b0, "R9", "wide full at 16", {tx_full_o, tx_ovf_o}, 2'b10);
    push(16'hFFFF);
    chk(tx_ovf_o == 1'b1, "R10", "wide overflow flag", tx_ovf_o, 1);
    repeat (20) @(negedge clk);
    chk(tx_ovf_o == 1'b1, "R10", "overflow sticky", tx_ovf_o, 1);

    // R9/R10: narrow depth 32
    do_reset();
    clk_div_i = 8'd50;
    for (int k = 0; k < 31; k++) push(16'(k));
    chk(tx_full_o == 1'b0, "R9", "narrow not full at 30", tx_full_o, 0);
    push(16'h0A); push(16'h0B);
    chk(tx_full_o == 1'b1 && tx_ovf_o == 1'b0, "R9", "narrow full at 32", {tx_full_o, tx_ovf_o}, 2'b10);
    push(16'h0C);
    chk(tx_ovf_o == 1'b1, "R10", "narrow overflow flag", tx_ovf_o, 1);

    // R11: rx overrun in narrow separated mode
    do_reset();
    clk_div_i = 8'd1;
    mon_reset();
    for (int k = 0; k < 32; k++) push(16'(k));
    repeat (32 * 24 + 50) @(negedge clk);
    chk(rx_ovr_o == 1'b0 && rx_valid_o == 1'b1, "R11", "32 stored no overrun",
        {rx_ovr_o, rx_valid_o}, 2'b01);
    push(16'h5A);
    repeat (60) @(negedge clk);
    chk(rx_ovr_o == 1'b1, "R11", "overrun flag", rx_ovr_o, 1);
    for (int k = 0; k < 32; k++) begin
      chk(rx_valid_o && rx_data_o == 16'h00C3, "R11", "kept entry", rx_data_o, 16'h00C3);
      pop();
    end
    chk(rx_valid_o == 1'b0 && rx_ovr_o == 1'b1, "R11", "extra word dropped, flag sticky",
        {rx_valid_o, rx_ovr_o}, 2'b01);

    report();
  end
endmodule